// File: doc/BRIEF.md
# Word-wide string length engine

This block measures the length of a zero-terminated byte string held in memory. Software presents a start address together with a one-cycle start pulse and a strict-alignment option. The engine then fetches the string through a simple request/acknowledge read port and returns the number of characters before the terminating zero byte, or an error code, together with a one-cycle done pulse.

From an unaligned start, the engine fetches single bytes until the address reaches a word boundary. It then fetches whole 32-bit words. In each word, one zero detector per byte lane works in parallel, and a lowest-lane-first priority encoder finds the terminator. A null start address and a rejected unaligned address produce distinct codes without any memory traffic. Word scanning stops at a fixed length cap.

Top module: `strscan_engine`

## Requirements
- R1: A start address of 0 is accepted as a null pointer. No read request is issued, and the next cycle shows done_o = 1 with result_o = 0xFFFFFFF0.
- R2: When strict_i = 1 and the start address has a non-zero value in bits 1:0, no read is issued, and the next cycle shows done_o = 1 with result_o = 0xFFFFFFFF. An aligned start under strict_i = 1 is scanned normally.
- R3: When strict_i = 0 and the start is unaligned, the engine issues byte reads (rd_word_o = 0). Each non-zero byte adds 1 to the count and moves the address up by 1. A zero byte ends the scan with the count reached so far.
- R4: As soon as address bits 1:0 are 00, the engine issues word reads (rd_word_o = 1) at the current address. A word read is never issued at an unaligned address.
- R5: Word data is little-endian: bits 7:0 hold the earliest character, then bits 15:8, 23:16 and 31:24. If lane k (0..3) is the lowest lane that holds a zero byte, the result is the count plus k.
- R6: A word with no zero lane adds 4 to the count, and the next word, 4 bytes higher, is read.
- R7: During word scanning, if the count plus 4 reaches 0xFF00 (65280) without a zero lane, the scan stops with result_o = 0xFF00. A string of 65279 characters still reports 65279.
- R8: For a byte read, the byte is taken from the lane of rd_data_i selected by rd_addr_o bits 1:0 (lane 0 = bits 7:0).
- R9: rd_req_o stays high, with rd_addr_o and rd_word_o unchanged, until rd_ack_i is seen. Only one read is outstanding at a time.
- R10: busy_o is high from the cycle after an accepted start until the scan ends. A start pulse while busy_o = 1 is ignored.
- R11: done_o is a one-cycle pulse with busy_o = 0. result_o keeps its value from the done pulse until the next accepted start. After reset, busy_o, done_o, rd_req_o and result_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| addr_i | input | 32 | Start address of the string |
| strict_i | input | 1 | 1 = reject unaligned start addresses |
| busy_o | output | 1 | Scan in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 32 | Character count or error code |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | 32 | Read address |
| rd_word_o | output | 1 | Read size: 1 = word, 0 = byte |
| rd_data_i | input | 32 | Read data, a whole aligned word |
| rd_ack_i | input | 1 | Read acknowledge, completes the read |

## Verification
The assertions check the following on every cycle:
- the read-port handshake: the request holds steady until it is acknowledged;
- that the size bit agrees with the address alignment;
- that start is ignored while busy, and that the result holds while idle;
- the immediate error codes, with no memory traffic, for null and rejected addresses;
- that no reported length exceeds the cap.

Only the bench's scenarios can show that the counted length is right. These scenarios cover lane priority in little-endian words, the byte prologue from each misalignment, the exact number of byte reads, and the saturation boundary at 65279 and 65280 characters. They run against a memory model with random acknowledge latency.

// File: rtl/strscan_pkg.sv
`timescale 1ns/1ps
package strscan_pkg;
   typedef enum logic [1:0] {
      SCAN_IDLE = 2'd0,
      SCAN_BYTE = 2'd1,
      SCAN_WORD = 2'd2
   } scan_state_e;

   localparam int RES_W = 32;
   localparam logic [RES_W-1:0] CODE_NULL_PTR  = 32'hFFFF_FFF0;
   localparam logic [RES_W-1:0] CODE_MISALIGN  = 32'hFFFF_FFFF;
endpackage

// File: rtl/strscan_lane_detect.sv
`timescale 1ns/1ps
// Per-lane zero detectors followed by a lowest-lane-first priority encoder.
module strscan_lane_detect #(
   parameter int LANES = 4,
   localparam int SEL_W = $clog2(LANES)
) (
   input  logic [LANES*8-1:0] word_i,
   output logic               any_zero_o,
   output logic [SEL_W-1:0]   first_idx_o
);
   logic [LANES-1:0] lane_zero;
   logic [LANES:0]   lower_hit;
   logic [LANES-1:0] first_oh;

   assign lower_hit[0] = 1'b0;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      // eight-input NOR per lane
      assign lane_zero[g]   = ~|word_i[g*8 +: 8];
      assign first_oh[g]    = lane_zero[g] & ~lower_hit[g];
      assign lower_hit[g+1] = lower_hit[g] | lane_zero[g];
   end

   assign any_zero_o = lower_hit[LANES];

   always_comb begin
      first_idx_o = '0;
      for (int i = 0; i < LANES; i++) begin
         if (first_oh[i]) first_idx_o = first_idx_o | SEL_W'(i);
      end
   end
endmodule

// File: rtl/strscan_byte_pick.sv
`timescale 1ns/1ps
// Selects one byte lane of a returned word by the low address bits.
module strscan_byte_pick #(
   parameter int LANES = 4,
   localparam int SEL_W = $clog2(LANES)
) (
   input  logic [LANES*8-1:0] word_i,
   input  logic [SEL_W-1:0]   sel_i,
   output logic [7:0]         byte_o
);
   logic [7:0] lane_b [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_split
      assign lane_b[g] = word_i[g*8 +: 8];
   end

   assign byte_o = lane_b[sel_i];
endmodule

// File: rtl/strscan_count_step.sv
`timescale 1ns/1ps
// Count arithmetic for one word: final length on a hit, step and cap test on a miss.
module strscan_count_step #(
   parameter int LANES   = 4,
   parameter int CNT_W   = 17,
   parameter int LEN_CAP = 65280,
   localparam int SEL_W = $clog2(LANES)
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [SEL_W-1:0] idx_i,
   output logic [CNT_W-1:0] hit_len_o,
   output logic [CNT_W-1:0] step_o,
   output logic             at_cap_o
);
   localparam logic [CNT_W-1:0] CAP_C  = CNT_W'(LEN_CAP);
   localparam logic [CNT_W-1:0] STEP_C = CNT_W'(LANES);

   assign hit_len_o = cnt_i + {{(CNT_W-SEL_W){1'b0}}, idx_i};
   assign step_o    = cnt_i + STEP_C;
   assign at_cap_o  = (step_o >= CAP_C);
endmodule

// File: rtl/strscan_engine.sv
`timescale 1ns/1ps
module strscan_engine #(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int CNT_W   = 17,
   parameter int LEN_CAP = 65280
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              strict_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [31:0]       result_o,
   output logic              rd_req_o,
   output logic [ADDR_W-1:0] rd_addr_o,
   output logic              rd_word_o,
   input  logic [DATA_W-1:0] rd_data_i,
   input  logic              rd_ack_i
);
   import strscan_pkg::*;

   localparam int LANES = DATA_W / 8;
   localparam int SEL_W = $clog2(LANES);
   localparam logic [RES_W-1:0] CAP_RES = RES_W'(LEN_CAP);

   // elaboration-time parameter checks
   if ((DATA_W % 8) != 0 || LANES < 2 || (LANES & (LANES - 1)) != 0) begin : g_bad_data
      $error("DATA_W must be a power-of-two number of bytes, at least two");
   end
   if (CNT_W > RES_W || (LEN_CAP + LANES) >= (2 ** CNT_W)) begin : g_bad_cnt
      $error("CNT_W must hold LEN_CAP plus one word and fit the result");
   end
   if (ADDR_W < SEL_W + 1) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   scan_state_e       state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [RES_W-1:0]  result_q;
   logic              done_q;

   logic              any_zero;
   logic [SEL_W-1:0]  first_idx;
   logic [7:0]        picked_byte;
   logic [CNT_W-1:0]  hit_len;
   logic [CNT_W-1:0]  step_cnt;
   logic              at_cap;
   logic              start_unaligned;
   logic              last_byte_lane;

   strscan_lane_detect #(.LANES(LANES)) u_detect (
      .word_i      (rd_data_i),
      .any_zero_o  (any_zero),
      .first_idx_o (first_idx)
   );

   strscan_byte_pick #(.LANES(LANES)) u_pick (
      .word_i (rd_data_i),
      .sel_i  (addr_q[SEL_W-1:0]),
      .byte_o (picked_byte)
   );

   strscan_count_step #(.LANES(LANES), .CNT_W(CNT_W), .LEN_CAP(LEN_CAP)) u_step (
      .cnt_i     (cnt_q),
      .idx_i     (first_idx),
      .hit_len_o (hit_len),
      .step_o    (step_cnt),
      .at_cap_o  (at_cap)
   );

   assign start_unaligned = |addr_i[SEL_W-1:0];
   assign last_byte_lane  = (addr_q[SEL_W-1:0] == SEL_W'(LANES - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= SCAN_IDLE;
         addr_q   <= '0;
         cnt_q    <= '0;
         result_q <= '0;
         done_q   <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SCAN_IDLE: begin
               if (start_i) begin
                  if (addr_i == '0) begin
                     result_q <= CODE_NULL_PTR;
                     done_q   <= 1'b1;
                  end else if (strict_i && start_unaligned) begin
                     result_q <= CODE_MISALIGN;
                     done_q   <= 1'b1;
                  end else begin
                     addr_q  <= addr_i;
                     cnt_q   <= '0;
                     state_q <= start_unaligned ? SCAN_BYTE : SCAN_WORD;
                  end
               end
            end
            SCAN_BYTE: begin
               if (rd_ack_i) begin
                  if (picked_byte == 8'h00) begin
                     result_q <= RES_W'(cnt_q);
                     done_q   <= 1'b1;
                     state_q  <= SCAN_IDLE;
                  end else begin
                     cnt_q  <= cnt_q + CNT_W'(1);
                     addr_q <= addr_q + ADDR_W'(1);
                     if (last_byte_lane) state_q <= SCAN_WORD;
                  end
               end
            end
            SCAN_WORD: begin
               if (rd_ack_i) begin
                  if (any_zero) begin
                     result_q <= RES_W'(hit_len);
                     done_q   <= 1'b1;
                     state_q  <= SCAN_IDLE;
                  end else if (at_cap) begin
                     result_q <= CAP_RES;
                     done_q   <= 1'b1;
                     state_q  <= SCAN_IDLE;
                  end else begin
                     cnt_q  <= step_cnt;
                     addr_q <= addr_q + ADDR_W'(LANES);
                  end
               end
            end
            default: state_q <= SCAN_IDLE;
         endcase
      end
   end

   assign busy_o    = (state_q != SCAN_IDLE);
   assign rd_req_o  = (state_q == SCAN_BYTE) || (state_q == SCAN_WORD);
   assign rd_word_o = (state_q == SCAN_WORD);
   assign rd_addr_o = addr_q;
   assign done_o    = done_q;
   assign result_o  = result_q;

   // ---------------- assertions ----------------
   AST_NULL_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && addr_i == '0) |=> (done_o && !rd_req_o && result_o == CODE_NULL_PTR)); // R1
   AST_MISALIGN_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && start_i && strict_i && addr_i != '0 && start_unaligned)
      |=> (done_o && !rd_req_o && result_o == CODE_MISALIGN)); // R2
   AST_BYTE_UNALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_word_o) |-> (rd_addr_o[SEL_W-1:0] != '0)); // R3
   AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && rd_word_o) |-> (rd_addr_o[SEL_W-1:0] == '0)); // R4
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req_o && !rd_ack_i) |=> (rd_req_o && $stable(rd_addr_o) && $stable(rd_word_o))); // R9
   AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i && !rd_ack_i) |=> (busy_o && $stable(rd_addr_o) && !done_o)); // R10
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i) |=> $stable(result_o)); // R11
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o); // R11
   AST_NO_OVER_CAP: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && result_o < CODE_NULL_PTR) |-> (result_o <= CAP_RES)); // R7
endmodule

// File: tb/strscan_engine_tb_top.sv
`timescale 1ns/1ps
module strscan_engine_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [31:0] addr_i = '0;
   logic        strict_i = 1'b0;
   logic        busy_o, done_o, rd_req_o, rd_word_o;
   logic [31:0] result_o, rd_addr_o;
   logic [31:0] rd_data_i = '0;
   logic        rd_ack_i = 1'b0;

   always #2.5 clk = ~clk;

   strscan_engine dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i), .strict_i(strict_i),
      .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
      .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_word_o(rd_word_o),
      .rd_data_i(rd_data_i), .rd_ack_i(rd_ack_i)
   );

   int n_tests = 0, n_fail = 0;
   int byte_reads = 0, word_reads = 0, r4_bad = 0, r9_bad = 0;
   int lat_max = 3;
   bit aborted = 0;
   logic [31:0] base = '0;
   int slen = 0;

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // memory image: string of slen non-zero chars at base, then a zero
   function automatic logic [7:0] mem_byte(input logic [31:0] a);
      logic [31:0] off;
      off = a - base;
      if (off < 32'(slen)) return 8'h41 + 8'(off % 26);
      if (off == 32'(slen)) return 8'h00;
      return ((a % 3) == 0) ? 8'h00 : 8'h5C;
   endfunction

   function automatic logic [31:0] word_at(input logic [31:0] a);
      logic [31:0] w;
      for (int i = 0; i < 4; i++) w[i*8 +: 8] = mem_byte({a[31:2], 2'b00} + 32'(i));
      return w;
   endfunction

   function automatic logic [31:0] exp_len(input logic [31:0] a, input bit strict, input int len);
      int cnt;
      if (a == 0) return 32'hFFFF_FFF0;
      if (strict && a[1:0] != 2'b00) return 32'hFFFF_FFFF;
      cnt = (4 - int'(a[1:0])) % 4;
      if (len < cnt) return 32'(len);
      forever begin
         if (len < cnt + 4) return 32'(len);
         if (cnt + 4 >= 65280) return 32'd65280;
         cnt += 4;
      end
   endfunction

   // responder: random acknowledge latency, whole aligned word returned
   initial begin
      int wait_left = 0;
      bit prev_pend = 0;
      logic [31:0] prev_addr = '0;
      logic prev_word = 1'b0;
      forever begin
         @(negedge clk);
         if (prev_pend && (!rd_req_o || rd_addr_o != prev_addr || rd_word_o != prev_word)) r9_bad++;
         rd_ack_i = 1'b0;
         prev_pend = 0;
         if (rd_req_o) begin
            if (wait_left == 0) begin
               rd_ack_i  = 1'b1;
               rd_data_i = word_at(rd_addr_o);
               if (rd_word_o) begin
                  word_reads++;
                  if (rd_addr_o[1:0] != 2'b00) r4_bad++;
               end else byte_reads++;
               wait_left = (lat_max > 0) ? int'($urandom_range(0, lat_max)) : 0;
            end else begin
               wait_left--;
               prev_pend = 1;
               prev_addr = rd_addr_o;
               prev_word = rd_word_o;
            end
         end
      end
   end

   task automatic run_scan(input logic [31:0] a, input bit strict, input int len, input bit poke, input string tag);
      logic [31:0] exp;
      int br0, wr0, cyc, p, exp_br;
      bit err;
      if (aborted) return;
      base = a; slen = len;
      exp = exp_len(a, strict, len);
      err = (a == 0) || (strict && a[1:0] != 2'b00);
      @(negedge clk);
      br0 = byte_reads; wr0 = word_reads;
      start_i = 1'b1; addr_i = a; strict_i = strict;
      @(negedge clk);
      start_i = 1'b0; addr_i = '0; strict_i = 1'b0;
      if (err) begin
         check(done_o && !busy_o, tag, {30'd0, done_o, busy_o}, 32'd2);
      end else begin
         check(busy_o, "R10", {31'd0, busy_o}, 32'd1);
         if (poke) begin
            @(negedge clk);
            check(busy_o, "R10", {31'd0, busy_o}, 32'd1);
            start_i = 1'b1; addr_i = '0;     // null start while busy: must be ignored
            @(negedge clk);
            start_i = 1'b0;
         end
         cyc = 0;
         while (!done_o && cyc < 100000) begin
            @(negedge clk);
            cyc++;
         end
         if (!done_o) begin
            check(1'b0, "watchdog", 32'(cyc), 32'd0);
            aborted = 1;
            return;
         end
      end
      check(result_o == exp, tag, result_o, exp);
      if (err) begin
         check(byte_reads == br0 && word_reads == wr0, tag, 32'(byte_reads - br0 + word_reads - wr0), 32'd0);
      end else begin
         p = (4 - int'(a[1:0])) % 4;
         exp_br = (len < p) ? len + 1 : p;
         check(byte_reads - br0 == exp_br, "R3", 32'(byte_reads - br0), 32'(exp_br));
      end
      @(negedge clk);
      check(!done_o && result_o == exp, "R11", result_o, exp);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy_o && !done_o && !rd_req_o && result_o == 0, "R11", result_o, 32'd0);

      run_scan(32'h0, 1'b0, 5, 0, "R1");
      run_scan(32'h0, 1'b1, 5, 0, "R1");
      run_scan(32'h1003, 1'b1, 5, 0, "R2");
      run_scan(32'h2001, 1'b1, 5, 0, "R2");
      run_scan(32'h5000, 1'b1, 10, 0, "R2");
      for (int k = 0; k < 4; k++) run_scan(32'h3000, 1'b0, k, 0, "R5");
      for (int k = 4; k < 8; k++) run_scan(32'h3000, 1'b0, k, 0, "R6");
      run_scan(32'h4001, 1'b0, 0, 0, "R3");
      run_scan(32'h4001, 1'b0, 1, 0, "R3");
      run_scan(32'h4001, 1'b0, 2, 0, "R3");
      run_scan(32'h4001, 1'b0, 3, 0, "R4");
      run_scan(32'h4002, 1'b0, 9, 0, "R8");
      run_scan(32'h4003, 1'b0, 6, 0, "R8");
      run_scan(32'h6000, 1'b0, 40, 1, "R10");

      for (int i = 0; i < 30; i++) begin
         logic [31:0] ra;
         ra = ($urandom & 32'h0FFF_FFFF) | 32'h100;
         run_scan(ra, 1'($urandom % 2), int'($urandom_range(0, 40)), 0, "R5");
      end

      lat_max = 0;
      run_scan(32'h7000, 1'b0, 70000, 0, "R7");
      run_scan(32'h7001, 1'b0, 70000, 0, "R7");
      run_scan(32'h8000, 1'b0, 65279, 0, "R7");

      check(r4_bad == 0, "R4", 32'(r4_bad), 32'd0);
      check(r9_bad == 0, "R9", 32'(r9_bad), 32'd0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule